// File: doc/BRIEF.md
# NAND Flash Bridge with Programmable Timing

This block connects a 32-bit memory-mapped slave port to a byte-wide asynchronous NAND flash. It generates chip select, read and write strobes and the command and address latch lines, and it times every flash byte cycle with its own counters. While a cycle is in progress it keeps the master stalled through a wait signal. The wait signal is not tied to fixed bus wait states, so the length of each access is set by the bridge itself.

Two timing profiles are built in. After reset the bridge uses the slow one, which matches the flash's power-up interface mode. Software first sends the flash its timing-mode change command through the bridge. It then writes a mode bit in the bridge's control register, and from the next flash cycle on the bridge uses the fast profile. Each profile gives a setup length, a strobe-low length and a hold length, all counted in clock cycles.

The upper address bits choose the kind of access, all within one slave port. Window 0 moves a whole 32-bit word as four byte cycles. Window 1 moves exactly one byte. This matters on a streamed device, because every extra read strobe consumes a byte. Window 2 sends a byte with the command latch line high. Window 3 sends a byte with the address latch line high. Window 4 holds the control register.

Top module: `nand_timing_bridge`

## Requirements
- R1: After reset the flash lines are idle (ce_n, re_n and we_n high; cle, ale and dq_oe low), the wait signal is low with no request, and the control register reads back 0, which selects the slow profile.
- R2: Under the slow profile every flash byte cycle has 3 setup cycles, 6 strobe-low cycles and 3 hold cycles. An access of n byte cycles keeps bus_waitreq high for 1 + 12·n cycles.
- R3: Window 4 (bus_addr = 3'd4) is the control register. A write stores bus_wdata[0] as the mode bit (1 = fast), and a read returns the bit in bit 0 with all other bits zero. A control access holds wait for exactly one cycle and causes no flash cycle.
- R4: Under the fast profile every byte cycle has 1 setup cycle, 2 strobe-low cycles and 1 hold cycle, so bus_waitreq stays high for 1 + 4·n cycles. The profile is chosen at the start of each byte cycle.
- R5: A read in window 0 performs four consecutive byte reads and packs them little-endian: the first byte goes to bits [7:0] and the fourth to bits [31:24].
- R6: A read in window 1 performs exactly one byte read and returns it in bits [7:0] with bits [31:8] zero. The next read continues from the following byte.
- R7: A write in window 0 sends four bytes in the order bus_wdata[7:0], [15:8], [23:16], [31:24], each latched by the flash on the rising edge of we_n, with cle and ale low.
- R8: A write in window 2 sends bus_wdata[7:0] as one byte with cle high and ale low. A write in window 3 does the same with ale high and cle low. The latch line stays high for the whole byte cycle, and cle and ale are never high together.
- R9: dq_oe is high only during write byte cycles, from the first setup cycle through the last hold cycle, and never while re_n is low.
- R10: ce_n is low from the first setup cycle of an access through its final hold cycle and high otherwise. A strobe is never low while ce_n is high, and ce_n is only low while the master is being held.
- R11: A read or write in windows 5 to 7 completes after one wait cycle, causes no flash cycle, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Upper address bits selecting the access window |
| bus_read | input | 1 | Read request, held until bus_waitreq is low |
| bus_write | input | 1 | Write request, held until bus_waitreq is low |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_waitreq is low |
| bus_waitreq | output | 1 | Stalls the master while the access is in progress |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_dq_out | output | 8 | Byte driven toward the flash |
| fl_dq_oe | output | 1 | Output enable for fl_dq_out |
| fl_dq_in | input | 8 | Byte returned by the flash |

## Verification
The bench builds the bridge with its default parameters: four byte lanes, three window bits, a slow profile of 3/6/3 and a fast profile of 1/2/1. These values give every access shape its own wait length: 49, 17, 13 and 5 cycles. A swapped profile, a missing byte cycle or an extra byte cycle therefore shows up directly in the stall count and in the strobe and enable run lengths. The three window bits also reach the unused windows 5 to 7. The streamed flash model hands out a new byte on each read-strobe rise, so a single-byte read that pulls extra bytes shifts every later word.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  // Sequencer phases of one flash access
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_LOW   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  // Decoded meaning of an address window
  typedef struct packed {
    logic flash;  // access reaches the flash
    logic multi;  // full word, one byte per lane
    logic cle;    // command latch high during the cycle
    logic ale;    // address latch high during the cycle
    logic ctrl;   // bridge control register
  } access_t;

  localparam int WIN_WORD = 0;
  localparam int WIN_BYTE = 1;
  localparam int WIN_CMD  = 2;
  localparam int WIN_ALE  = 3;
  localparam int WIN_CTRL = 4;

endpackage

// File: rtl/nbr_decode.sv
module nbr_decode
  import nbr_pkg::*;
#(
  parameter int WIN_W = 3
) (
  input  logic [WIN_W-1:0] win,
  output access_t          acc
);

  always_comb begin
    acc = '0;
    if (win == WIN_W'(WIN_WORD)) begin
      acc.flash = 1'b1;
      acc.multi = 1'b1;
    end else if (win == WIN_W'(WIN_BYTE)) begin
      acc.flash = 1'b1;
    end else if (win == WIN_W'(WIN_CMD)) begin
      acc.flash = 1'b1;
      acc.cle   = 1'b1;
    end else if (win == WIN_W'(WIN_ALE)) begin
      acc.flash = 1'b1;
      acc.ale   = 1'b1;
    end else if (win == WIN_W'(WIN_CTRL)) begin
      acc.ctrl  = 1'b1;
    end
  end

endmodule

// File: rtl/nbr_profile.sv
module nbr_profile
  import nbr_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SLOW_SETUP = 3,
  parameter int SLOW_LOW   = 6,
  parameter int SLOW_HOLD  = 3,
  parameter int FAST_SETUP = 1,
  parameter int FAST_LOW   = 2,
  parameter int FAST_HOLD  = 1
) (
  input  logic             fast,
  input  phase_e           target,
  output logic [CNT_W-1:0] load
);

  // Counter preload is the phase length minus one
  always_comb begin
    case (target)
      PH_SETUP: load = fast ? CNT_W'(FAST_SETUP - 1) : CNT_W'(SLOW_SETUP - 1);
      PH_LOW:   load = fast ? CNT_W'(FAST_LOW - 1)   : CNT_W'(SLOW_LOW - 1);
      default:  load = fast ? CNT_W'(FAST_HOLD - 1)  : CNT_W'(SLOW_HOLD - 1);
    endcase
  end

endmodule

// File: rtl/nbr_packer.sv
module nbr_packer #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 4,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    cap,
  input  logic [IDX_W-1:0]        idx,
  input  logic [BYTE_W-1:0]       din,
  output logic [BYTE_W*BYTES-1:0] word
);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        lane_q <= '0;
      else if (cap && idx == IDX_W'(g))
        lane_q <= din;
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/nand_timing_bridge.sv
module nand_timing_bridge
  import nbr_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int BYTE_W     = 8,
  parameter int BYTES      = 4,
  parameter int SLOW_SETUP = 3,
  parameter int SLOW_LOW   = 6,
  parameter int SLOW_HOLD  = 3,
  parameter int FAST_SETUP = 1,
  parameter int FAST_LOW   = 2,
  parameter int FAST_HOLD  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_read,
  input  logic                    bus_write,
  input  logic [BYTES*BYTE_W-1:0] bus_wdata,
  output logic [BYTES*BYTE_W-1:0] bus_rdata,
  output logic                    bus_waitreq,
  output logic                    fl_ce_n,
  output logic                    fl_re_n,
  output logic                    fl_we_n,
  output logic                    fl_cle,
  output logic                    fl_ale,
  output logic [BYTE_W-1:0]       fl_dq_out,
  output logic                    fl_dq_oe,
  input  logic [BYTE_W-1:0]       fl_dq_in
);

  localparam int WORD_W = BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(SLOW_SETUP + SLOW_LOW + SLOW_HOLD +
                                 FAST_SETUP + FAST_LOW + FAST_HOLD + 1);
  localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

  phase_e            phase_q, nxt, load_tgt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, load_val;
  logic [IDX_W-1:0]  idx_q, idx_nxt;
  access_t           acc_dec, acc_q, acc_eff;
  logic              wr_q, wr_eff, mode_q, fast_q, fast_nxt, prof_fast;
  logic              req, in_idle, cnt_zero, last_byte, active_nxt, cap;
  logic [WORD_W-1:0] wdata_q, data_eff, packed_word, rdata_q;
  logic              ce_n_q, re_n_q, we_n_q, cle_q, ale_q, oe_q;
  logic [BYTE_W-1:0] dq_q;

  nbr_decode #(.WIN_W(ADDR_W)) u_decode (
    .win (bus_addr),
    .acc (acc_dec)
  );

  nbr_profile #(
    .CNT_W(CNT_W),
    .SLOW_SETUP(SLOW_SETUP), .SLOW_LOW(SLOW_LOW), .SLOW_HOLD(SLOW_HOLD),
    .FAST_SETUP(FAST_SETUP), .FAST_LOW(FAST_LOW), .FAST_HOLD(FAST_HOLD)
  ) u_profile (
    .fast   (prof_fast),
    .target (load_tgt),
    .load   (load_val)
  );

  nbr_packer #(.BYTE_W(BYTE_W), .BYTES(BYTES), .IDX_W(IDX_W)) u_packer (
    .clk  (clk),
    .rst  (rst),
    .clr  (in_idle && req),
    .cap  (cap),
    .idx  (idx_q),
    .din  (fl_dq_in),
    .word (packed_word)
  );

  assign req      = bus_read || bus_write;
  assign in_idle  = (phase_q == PH_IDLE);
  assign acc_eff  = in_idle ? acc_dec   : acc_q;
  assign wr_eff   = in_idle ? bus_write : wr_q;
  assign data_eff = in_idle ? bus_wdata : wdata_q;
  assign cnt_zero = (cnt_q == '0);
  assign last_byte = acc_eff.multi ? (idx_q == IDX_W'(BYTES - 1)) : 1'b1;
  // Read byte is taken on the edge that ends the strobe-low phase
  assign cap      = (phase_q == PH_LOW) && cnt_zero && !wr_q;

  always_comb begin
    nxt       = phase_q;
    cnt_nxt   = cnt_q - CNT_W'(1);
    idx_nxt   = idx_q;
    load_tgt  = PH_SETUP;
    prof_fast = fast_q;
    fast_nxt  = fast_q;
    case (phase_q)
      PH_IDLE: begin
        cnt_nxt = cnt_q;
        if (req) begin
          if (acc_dec.flash) begin
            nxt       = PH_SETUP;
            prof_fast = mode_q;
            fast_nxt  = mode_q;
            cnt_nxt   = load_val;
            idx_nxt   = '0;
          end else begin
            nxt = PH_DONE;
          end
        end
      end
      PH_SETUP: if (cnt_zero) begin
        nxt      = PH_LOW;
        load_tgt = PH_LOW;
        cnt_nxt  = load_val;
      end
      PH_LOW: if (cnt_zero) begin
        nxt      = PH_HOLD;
        load_tgt = PH_HOLD;
        cnt_nxt  = load_val;
      end
      PH_HOLD: if (cnt_zero) begin
        if (last_byte) begin
          nxt = PH_DONE;
        end else begin
          // profile is re-sampled at each byte cycle boundary
          nxt       = PH_SETUP;
          idx_nxt   = idx_q + IDX_W'(1);
          prof_fast = mode_q;
          fast_nxt  = mode_q;
          cnt_nxt   = load_val;
        end
      end
      PH_DONE: begin
        nxt     = PH_IDLE;
        cnt_nxt = cnt_q;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign active_nxt = (nxt == PH_SETUP) || (nxt == PH_LOW) || (nxt == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      wr_q    <= 1'b0;
      mode_q  <= 1'b0;
      fast_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ce_n_q  <= 1'b1;
      re_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      oe_q    <= 1'b0;
      dq_q    <= '0;
    end else begin
      phase_q <= nxt;
      cnt_q   <= cnt_nxt;
      idx_q   <= idx_nxt;
      fast_q  <= fast_nxt;
      if (in_idle && req) begin
        acc_q   <= acc_dec;
        wr_q    <= bus_write;
        wdata_q <= bus_wdata;
        if (acc_dec.ctrl && bus_write)
          mode_q <= bus_wdata[0];
      end
      if (nxt == PH_DONE && phase_q != PH_DONE) begin
        if (acc_eff.ctrl)
          rdata_q <= WORD_W'(mode_q);
        else if (acc_eff.flash && !wr_eff)
          rdata_q <= packed_word;
        else
          rdata_q <= '0;
      end
      ce_n_q <= !active_nxt;
      re_n_q <= !((nxt == PH_LOW) && !wr_eff);
      we_n_q <= !((nxt == PH_LOW) && wr_eff);
      cle_q  <= active_nxt && acc_eff.cle;
      ale_q  <= active_nxt && acc_eff.ale;
      oe_q   <= active_nxt && wr_eff;
      dq_q   <= data_eff[idx_nxt*BYTE_W +: BYTE_W];
    end
  end

  assign bus_waitreq = req && (phase_q != PH_DONE);
  assign bus_rdata   = rdata_q;
  assign fl_ce_n     = ce_n_q;
  assign fl_re_n     = re_n_q;
  assign fl_we_n     = we_n_q;
  assign fl_cle      = cle_q;
  assign fl_ale      = ale_q;
  assign fl_dq_oe    = oe_q;
  assign fl_dq_out   = dq_q;

endmodule

// File: rtl/nbr_checker.sv
module nbr_checker (
  input logic clk,
  input logic rst,
  input logic bus_waitreq,
  input logic fl_ce_n,
  input logic fl_re_n,
  input logic fl_we_n,
  input logic fl_cle,
  input logic fl_ale,
  input logic fl_dq_oe
);

  // R1: a reset cycle leaves every flash line idle
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (fl_ce_n && fl_re_n && fl_we_n && !fl_dq_oe && !fl_cle && !fl_ale));

  // R2: read strobe lasts at least two cycles in any profile
  a_r2_read_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_re_n) |=> !fl_re_n);

  // R4: write strobe lasts at least two cycles in any profile
  a_r4_write_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |=> !fl_we_n);

  // R8: the two latch lines never rise together
  a_r8_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));

  // R9: bridge never drives the data bus while the flash is asked to drive it
  a_r9_oe_not_in_read: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_re_n);

  // R10: strobes only inside chip enable
  a_r10_strobe_inside_ce: assert property (@(posedge clk) disable iff (rst)
    (!fl_re_n || !fl_we_n) |-> !fl_ce_n);

  // R10: chip enable only while the master is held
  a_r10_ce_while_held: assert property (@(posedge clk) disable iff (rst)
    !fl_ce_n |-> bus_waitreq);

endmodule

bind nand_timing_bridge nbr_checker u_nbr_checker (
  .clk         (clk),
  .rst         (rst),
  .bus_waitreq (bus_waitreq),
  .fl_ce_n     (fl_ce_n),
  .fl_re_n     (fl_re_n),
  .fl_we_n     (fl_we_n),
  .fl_cle      (fl_cle),
  .fl_ale      (fl_ale),
  .fl_dq_oe    (fl_dq_oe)
);

// File: tb/nand_timing_bridge_test.sv
module nand_timing_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_read = 1'b0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_waitreq;
  logic        fl_ce_n, fl_re_n, fl_we_n, fl_cle, fl_ale, fl_dq_oe;
  logic [7:0]  fl_dq_out, fl_dq_in;

  always #2 clk = ~clk;  // 250 MHz

  nand_timing_bridge uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_waitreq(bus_waitreq), .fl_ce_n(fl_ce_n), .fl_re_n(fl_re_n),
    .fl_we_n(fl_we_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int nchecks = 0;
  int nfail   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Streamed flash model: each rising read strobe moves to the next byte
  int unsigned rd_ptr = 0;
  function automatic logic [7:0] sb(input int unsigned i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  assign fl_dq_in = sb(rd_ptr);
  always @(posedge fl_re_n) if (!rst) rd_ptr++;

  // Scoreboard queues
  typedef struct { logic cle; logic ale; logic [7:0] d; string req; } wr_item_t;
  typedef struct { logic [31:0] w; string req; } rd_item_t;
  wr_item_t wq[$];
  rd_item_t rq[$];

  // Write monitor: the flash takes the byte on the rising write strobe
  always @(posedge fl_we_n) if (!rst) begin
    if (wq.size() == 0) begin
      check(1'b0, "R7", "unexpected flash write byte", {24'h0, fl_dq_out}, 32'h0);
    end else begin
      wr_item_t it;
      it = wq.pop_front();
      check(fl_dq_out == it.d, it.req, "write byte", {24'h0, fl_dq_out}, {24'h0, it.d});
      check({fl_cle, fl_ale} == {it.cle, it.ale}, it.req, "latch lines {cle,ale}",
            {30'h0, fl_cle, fl_ale}, {30'h0, it.cle, it.ale});
      check(fl_dq_oe, "R9", "oe during write strobe", {31'h0, fl_dq_oe}, 32'h1);
    end
  end

  // Read monitor and run-length monitors, sampled between edges
  int re_run = 0, re_last = 0, we_run = 0, we_last = 0;
  int oe_run = 0, oe_last = 0, ce_run = 0, ce_last = 0;
  always @(negedge clk) begin
    #1;
    if (!rst && bus_read && !bus_waitreq) begin
      if (rq.size() == 0) begin
        check(1'b0, "R5", "unexpected read completion", bus_rdata, 32'h0);
      end else begin
        rd_item_t it;
        it = rq.pop_front();
        check(bus_rdata == it.w, it.req, "read data", bus_rdata, it.w);
      end
    end
    if (!fl_re_n) re_run++; else if (re_run != 0) begin re_last = re_run; re_run = 0; end
    if (!fl_we_n) we_run++; else if (we_run != 0) begin we_last = we_run; we_run = 0; end
    if (fl_dq_oe) oe_run++; else if (oe_run != 0) begin oe_last = oe_run; oe_run = 0; end
    if (!fl_ce_n) ce_run++; else if (ce_run != 0) begin ce_last = ce_run; ce_run = 0; end
  end

  // Driver: holds the request until the wait signal drops
  task automatic xfer(input bit wr, input logic [2:0] win, input logic [31:0] wd,
                      output int waits);
    @(negedge clk);
    bus_addr  = win;
    bus_write = wr;
    bus_read  = !wr;
    bus_wdata = wd;
    waits     = 0;
    #1;
    while (bus_waitreq) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    bus_read  = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] win, input logic [31:0] exp,
                         input int exp_waits, input string req);
    rd_item_t it;
    int w;
    it.w = exp;
    it.req = req;
    rq.push_back(it);
    xfer(1'b0, win, 32'h0, w);
    check(w == exp_waits, req, "wait cycles on read", w, exp_waits);
  endtask

  task automatic push_wr(input logic cle, input logic ale, input logic [7:0] d,
                         input string req);
    wr_item_t it;
    it.cle = cle;
    it.ale = ale;
    it.d   = d;
    it.req = req;
    wq.push_back(it);
  endtask

  task automatic do_write(input logic [2:0] win, input logic [31:0] d,
                          input int exp_waits, input string req);
    int w;
    xfer(1'b1, win, d, w);
    check(w == exp_waits, req, "wait cycles on write", w, exp_waits);
  endtask

  function automatic logic [31:0] word_at(input int unsigned p);
    return {sb(p + 3), sb(p + 2), sb(p + 1), sb(p)};
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    int unsigned p0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: idle lines after reset
    check({fl_ce_n, fl_re_n, fl_we_n} == 3'b111, "R1", "ce_n/re_n/we_n idle",
          {29'h0, fl_ce_n, fl_re_n, fl_we_n}, 32'h7);
    check({fl_cle, fl_ale, fl_dq_oe, bus_waitreq} == 4'b0, "R1", "cle/ale/oe/wait idle",
          {28'h0, fl_cle, fl_ale, fl_dq_oe, bus_waitreq}, 32'h0);

    // R1, R3: mode bit reads back slow after reset
    do_read(3'd4, 32'h0, 1, "R1");

    // R2, R5: slow word read, little-endian packing
    do_read(3'd0, word_at(0), 49, "R5");
    check(re_last == 6, "R2", "slow read strobe length", re_last, 6);
    check(ce_last == 48, "R10", "ce_n low span of slow word", ce_last, 48);

    // R6: single byte read pulls exactly one byte
    do_read(3'd1, {24'h0, sb(4)}, 13, "R6");
    check(rd_ptr == 5, "R6", "flash bytes consumed by byte read", rd_ptr, 5);
    do_read(3'd0, word_at(5), 49, "R6");

    // R8: command and address latch writes, slow
    push_wr(1'b1, 1'b0, 8'h90, "R8");
    do_write(3'd2, 32'hFFFF_FF90, 13, "R8");
    check(we_last == 6, "R2", "slow write strobe length", we_last, 6);
    check(oe_last == 12, "R9", "oe span of one slow write byte", oe_last, 12);
    push_wr(1'b0, 1'b1, 8'h5A, "R8");
    do_write(3'd3, 32'h0000_125A, 13, "R8");

    // R11: unused windows touch nothing
    p0 = rd_ptr;
    do_read(3'd5, 32'h0, 1, "R11");
    do_write(3'd7, 32'hDEAD_BEEF, 1, "R11");
    check(rd_ptr == p0, "R11", "flash bytes consumed by unused window", rd_ptr, p0);
    check(wq.size() == 0, "R11", "pending writes after unused window", wq.size(), 0);

    // R3: select fast profile and read it back
    do_write(3'd4, 32'hFFFF_FFF1, 1, "R3");
    do_read(3'd4, 32'h1, 1, "R3");

    // R4, R5: fast word read
    p0 = rd_ptr;
    do_read(3'd0, word_at(p0), 17, "R4");
    check(re_last == 2, "R4", "fast read strobe length", re_last, 2);

    // R7: fast word write, byte order
    push_wr(1'b0, 1'b0, 8'hD4, "R7");
    push_wr(1'b0, 1'b0, 8'hC3, "R7");
    push_wr(1'b0, 1'b0, 8'hB2, "R7");
    push_wr(1'b0, 1'b0, 8'hA1, "R7");
    do_write(3'd0, 32'hA1B2_C3D4, 17, "R7");
    check(we_last == 2, "R4", "fast write strobe length", we_last, 2);
    check(oe_last == 16, "R9", "oe span of fast word write", oe_last, 16);
    check(ce_last == 16, "R10", "ce_n low span of fast word", ce_last, 16);

    // R4, R6: fast single byte
    p0 = rd_ptr;
    do_read(3'd1, {24'h0, sb(p0)}, 5, "R6");
    push_wr(1'b1, 1'b0, 8'h30, "R8");
    do_write(3'd2, 32'h0000_0030, 5, "R4");

    // R3: back to slow
    do_write(3'd4, 32'h0, 1, "R3");
    p0 = rd_ptr;
    do_read(3'd1, {24'h0, sb(p0)}, 13, "R3");

    repeat (4) @(negedge clk);
    check(wq.size() == 0, "R7", "write bytes never seen", wq.size(), 0);
    check(rq.size() == 0, "R5", "reads never completed", rq.size(), 0);
    summary();
    $finish;
  end

endmodule